// File: doc/BRIEF.md
# Streaming Lane Burst Framer

This block sits on the transmit side of a multi-lane streaming link. Each cycle it may receive one user word that is 64 bits wide per lane. The word comes with a valid flag, start-of-burst and end-of-burst flags, and an 8-bit sync tag. Every cycle, each lane emits a 64-bit lane word with a 2-bit type header. When a buffered user word is waiting, the block cuts it into 64-bit slices, one slice per lane. When nothing is waiting, it sends idle words. The first word of a burst is preceded on every lane by a burst marker that carries the sync tag.

The lane stream is divided into metaframes of a programmable length. The last word of each metaframe is a diagnostic word that holds a CRC-32 of the lane's preceding words in that metaframe. Markers and diagnostic words take output slots away from data, so a small input buffer absorbs the difference. A word that arrives while that buffer is full is dropped and reported on the error output.

All lanes are driven by one sequencer with states ST_IDLE, ST_MARK, ST_DATA and ST_DIAG. The state names the word type emitted in a cycle. The next state is chosen by priority:
- ST_DIAG when the metaframe position reaches its last slot.
- Otherwise ST_MARK when the buffered head word opens a burst and its marker has not yet gone out.
- Otherwise ST_DATA when a word is buffered.
- Otherwise ST_IDLE.

The metaframe position is rewound on the transition into ST_DIAG.

Top module: `lane_burst_framer`

## Requirements
- R1: Lane g carries bits [64g+63:64g] of a buffered user word, with header 2'b01 (data). All lanes always carry the same header.
- R2: When no buffered word is pending, every lane sends header 2'b10 (idle) with a payload of 8'h1E in bits [63:56] and zeros elsewhere.
- R3: A word with start-of-burst set is preceded, ignoring any diagnostic words in between, by exactly one marker on every lane. A marker has header 2'b11 and payload {8'hB5, 48'h0, sync}.
- R4: Accepted user words leave in arrival order, each exactly once, and none is lost.
- R5: Every lane emits a diagnostic word (header 2'b00) as the last word of each metaframe of L words. L is taken from meta_len in the cycle that emits the previous diagnostic word, or during reset for the first metaframe.
- R6: A meta_len value below 200 is treated as 200.
- R7: The diagnostic payload is {8'hD0, 24'h0, crc}. crc is the CRC-32 over the 64-bit payloads of the lane's L-1 preceding words of that metaframe, computed MSB first with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and no final inversion.
- R8: A valid word that arrives while the buffer holds FIFO_DEPTH words is dropped. error[0] is high in the next cycle, for one cycle per dropped word, and is low otherwise.
- R9: In that same cycle, error[1] reports that the dropped word had start-of-burst set and error[2] that it had end-of-burst set. Both are low when no word is dropped.
- R10: During reset every lane sends idle words and error is zero.
- R11: A word accepted while nothing else is pending appears on the lanes 2 cycles after it is presented, or 3 cycles if it opens a burst, unless a diagnostic word falls in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meta_len | input | LEN_W | Metaframe length in 64-bit words |
| in_valid | input | 1 | User word present |
| in_sob | input | 1 | First word of a burst |
| in_eob | input | 1 | Last word of a burst |
| in_sync | input | 8 | Sync tag carried by the burst marker |
| in_data | input | 64*LANES | User word |
| lane_hdr | output | 2*LANES | Per-lane type header |
| lane_word | output | 64*LANES | Per-lane 64-bit payload |
| error | output | 3 | Drop, dropped start word, dropped end word |

## Verification
The assertions check, on every cycle, that the metaframe position stays below the active length and rewinds on each diagnostic word. They also check that the active length never falls below the floor, that a marker is followed by data or a diagnostic word and never by a second marker, that the buffer count stays bounded and is never popped while empty, that a full buffer hit by a valid word raises the drop flag, and that each lane's CRC restarts after a diagnostic word. Some behaviours can only be shown by the bench scenarios, using a scoreboard of words it has sent:
- data order and integrity across lanes
- the exact CRC value
- the marker's sync contents
- the two- and three-cycle latency
- metaframe lengths after meta_len changes, including the clamp

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    // state encoding equals the lane type header emitted in that state
    typedef enum logic [1:0] {
        ST_DIAG = 2'b00,
        ST_DATA = 2'b01,
        ST_IDLE = 2'b10,
        ST_MARK = 2'b11
    } seq_state_e;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [7:0]  TAG_IDLE = 8'h1E;
    localparam logic [7:0]  TAG_MARK = 8'hB5;
    localparam logic [7:0]  TAG_DIAG = 8'hD0;

    // 64 bits folded into a CRC-32, most significant bit first
    function automatic logic [31:0] crc32_step64(input logic [31:0] c, input logic [63:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 63; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/lbf_fifo.sv
module lbf_fifo #(
    parameter int W     = 137,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          push;

    assign full      = (count_q == CW'(DEPTH));
    assign not_empty = (count_q != '0);
    assign push      = wr_valid && !full;
    assign head      = mem[rd_ptr_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count_q != '0));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/lbf_sequencer.sv
module lbf_sequencer
    import lbf_pkg::*;
#(
    parameter int LEN_W   = 13,
    parameter int LEN_MIN = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] meta_len,
    input  logic             head_valid,
    input  logic             head_sob,
    output seq_state_e       emit_next,
    output logic             pop
);
    localparam logic [LEN_W-1:0] FLOOR = LEN_W'(LEN_MIN);

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] pos_q, cur_len_q;
    logic             mark_sent_q;
    logic             frame_end;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] m);
        return (m < FLOOR) ? FLOOR : m;
    endfunction

    assign frame_end = (pos_q == cur_len_q - LEN_W'(1));

    // next-state selection
    always_comb begin
        if (frame_end)                             state_d = ST_DIAG;
        else if (head_valid && head_sob && !mark_sent_q) state_d = ST_MARK;
        else if (head_valid)                       state_d = ST_DATA;
        else                                       state_d = ST_IDLE;
    end

    // outputs towards the buffer and the lanes
    always_comb begin
        emit_next = state_d;
        unique case (state_d)
            ST_DATA:                  pop = 1'b1;
            ST_IDLE, ST_MARK, ST_DIAG: pop = 1'b0;
            default:                  pop = 1'b0;
        endcase
    end

    // state register with metaframe bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pos_q       <= '0;
            cur_len_q   <= clamp_len(meta_len);
            mark_sent_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_DIAG) begin
                pos_q     <= '0;
                cur_len_q <= clamp_len(meta_len);
            end else begin
                pos_q <= pos_q + LEN_W'(1);
            end
            if (state_d == ST_MARK)      mark_sent_q <= 1'b1;
            else if (state_d == ST_DATA) mark_sent_q <= 1'b0;
        end
    end

    assert_diag_rewinds_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIAG) |-> (pos_q == '0));

    assert_pos_bound_R5: assert property (@(posedge clk) disable iff (rst)
        pos_q < cur_len_q);

    assert_len_floor_R6: assert property (@(posedge clk) disable iff (rst)
        cur_len_q >= FLOOR);

    assert_mark_once_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MARK) |=> (state_q == ST_DATA || state_q == ST_DIAG));

endmodule

// File: rtl/lbf_lane.sv
module lbf_lane
    import lbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seq_state_e  kind,
    input  logic [63:0] head_word,
    input  logic [7:0]  head_sync,
    output logic [1:0]  hdr_o,
    output logic [63:0] word_o
);
    logic [63:0] payload;
    logic [31:0] crc_q;

    always_comb begin
        unique case (kind)
            ST_IDLE: payload = {TAG_IDLE, 56'h0};
            ST_MARK: payload = {TAG_MARK, 48'h0, head_sync};
            ST_DATA: payload = head_word;
            ST_DIAG: payload = {TAG_DIAG, 24'h0, crc_q};
            default: payload = {TAG_IDLE, 56'h0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_o  <= ST_IDLE;
            word_o <= {TAG_IDLE, 56'h0};
            crc_q  <= CRC_INIT;
        end else begin
            hdr_o  <= kind;
            word_o <= payload;
            crc_q  <= (kind == ST_DIAG) ? CRC_INIT : crc32_step64(crc_q, payload);
        end
    end

    assert_crc_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (hdr_o == ST_DIAG) |-> (crc_q == CRC_INIT));

endmodule

// File: rtl/lane_burst_framer.sv
module lane_burst_framer
    import lbf_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int FIFO_DEPTH = 4,
    parameter int LEN_W      = 13,
    parameter int LEN_MIN    = 200
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LEN_W-1:0]      meta_len,
    input  logic                  in_valid,
    input  logic                  in_sob,
    input  logic                  in_eob,
    input  logic [7:0]            in_sync,
    input  logic [64*LANES-1:0]   in_data,
    output logic [2*LANES-1:0]    lane_hdr,
    output logic [64*LANES-1:0]   lane_word,
    output logic [2:0]            error
);
    localparam int DW    = 64 * LANES;
    localparam int ENT_W = DW + 8 + 1;

    logic [ENT_W-1:0] head;
    logic             not_empty, full, pop, drop;
    seq_state_e       emit_next;
    logic [2:0]       err_q;

    assign drop  = in_valid && full;
    assign error = err_q;

    lbf_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (in_valid),
        .wr_data   ({in_sob, in_sync, in_data}),
        .pop       (pop),
        .head      (head),
        .not_empty (not_empty),
        .full      (full)
    );

    lbf_sequencer #(.LEN_W(LEN_W), .LEN_MIN(LEN_MIN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .meta_len   (meta_len),
        .head_valid (not_empty),
        .head_sob   (head[ENT_W-1]),
        .emit_next  (emit_next),
        .pop        (pop)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lbf_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .kind      (emit_next),
            .head_word (head[64*g +: 64]),
            .head_sync (head[DW +: 8]),
            .hdr_o     (lane_hdr[2*g +: 2]),
            .word_o    (lane_word[64*g +: 64])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 3'b000;
        else     err_q <= {drop && in_eob, drop && in_sob, drop};
    end

    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && full) |=> error[0]);

    assert_quiet_error_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (error == 3'b000));

endmodule

// File: tb/test_lane_burst_framer.sv
module test_lane_burst_framer;
    localparam int LANES = 2;
    localparam int DW    = 64 * LANES;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [12:0]     meta_len = 13'd200;
    logic            in_valid = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
    logic [7:0]      in_sync = 8'h0;
    logic [DW-1:0]   in_data = '0;
    logic [2*LANES-1:0] lane_hdr;
    logic [DW-1:0]   lane_word;
    logic [2:0]      error;

    always #4 clk = ~clk;   // 125 MHz

    lane_burst_framer #(.LANES(LANES)) i_lane_burst_framer (
        .clk, .rst, .meta_len, .in_valid, .in_sob, .in_eob, .in_sync, .in_data,
        .lane_hdr, .lane_word, .error
    );

    typedef struct {
        logic [DW-1:0] d;
        logic          sob;
        logic [7:0]    sync;
        int            t_drv;
        bit            was_empty;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    int   cyc = 0, wcount = 0, cur_l = 200, last_diag_t = -1, n_diag = 0, n_drop = 0;
    bit   running = 0, finished = 0;
    bit   prev_valid = 0, prev_sob = 0, prev_eob = 0;
    logic [1:0]  last_kind = 2'b10;
    logic [7:0]  last_mark_sync = 8'h0;
    logic [31:0] crc [LANES];

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [63:0] d);
        logic [31:0] r = c;
        for (int i = 63; i >= 0; i--) begin
            logic fb = r[31] ^ d[i];
            r = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic int clamp(input int m);
        return (m < 200) ? 200 : m;
    endfunction

    function automatic logic [DW-1:0] mk(input int k);
        logic [31:0] u = k;
        return {u * 32'h9E3779B1, u, ~u, u ^ 32'h5A5A5A5A};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic sample();
        logic [1:0] h0;
        // R8 / R9: error refers to the word presented one cycle earlier
        if (error[0]) begin
            chk(prev_valid, "R8 drop without input", 1, prev_valid);
            chk(error[2:1] == {prev_eob, prev_sob}, "R9 dropped word flags", error, {prev_eob, prev_sob, 1'b1});
            if (q.size() > 0) void'(q.pop_back());
            n_drop++;
        end else if (error[2:1] != 2'b00) begin
            chk(0, "R9 flags without drop", error, 0);
        end
        h0 = lane_hdr[1:0];
        for (int l = 1; l < LANES; l++)
            chk(lane_hdr[2*l +: 2] == h0, "R1 lanes share header", lane_hdr[2*l +: 2], h0);
        wcount++;
        if (h0 == 2'b00) begin
            chk(wcount == cur_l, (meta_len < 200) ? "R6 clamped metaframe length" : "R5 metaframe length", wcount, cur_l);
            for (int l = 0; l < LANES; l++) begin
                chk(lane_word[64*l +: 64] == {8'hD0, 24'h0, crc[l]}, "R7 diagnostic CRC",
                    lane_word[64*l +: 64], {8'hD0, 24'h0, crc[l]});
                crc[l] = 32'hFFFFFFFF;
            end
            cur_l = clamp(meta_len);
            wcount = 0;
            last_diag_t = cyc;
            n_diag++;
        end else begin
            if (wcount >= cur_l) chk(0, "R5 diagnostic missing", wcount, cur_l);
            for (int l = 0; l < LANES; l++) crc[l] = crc_step(crc[l], lane_word[64*l +: 64]);
            if (h0 == 2'b10) begin
                for (int l = 0; l < LANES; l++)
                    chk(lane_word[64*l +: 64] == {8'h1E, 56'h0}, "R2 idle payload", lane_word[64*l +: 64], {8'h1E, 56'h0});
            end else if (h0 == 2'b11) begin
                for (int l = 0; l < LANES; l++)
                    chk(lane_word[64*l+8 +: 56] == {8'hB5, 48'h0}, "R3 marker payload", lane_word[64*l +: 64], {8'hB5, 48'h0, lane_word[7:0]});
                chk(last_kind != 2'b11, "R3 single marker", last_kind, 2'b01);
                last_mark_sync = lane_word[7:0];
            end else begin
                if (q.size() == 0) begin
                    chk(0, "R4 unexpected data", lane_word, 0);
                end else begin
                    exp_t e = q.pop_front();
                    chk(lane_word == e.d, "R1 R4 lane data order", lane_word, e.d);
                    if (e.sob) begin
                        chk(last_kind == 2'b11, "R3 marker before burst", last_kind, 2'b11);
                        chk(last_mark_sync == e.sync, "R3 marker sync", last_mark_sync, e.sync);
                    end
                    if (e.was_empty && last_diag_t <= e.t_drv)
                        chk(cyc - e.t_drv == (e.sob ? 3 : 2), "R11 latency", cyc - e.t_drv, e.sob ? 3 : 2);
                end
            end
            last_kind = h0;
        end
    endtask

    task automatic step(input bit v, input bit s, input bit e, input logic [7:0] sy, input logic [DW-1:0] d);
        @(negedge clk);
        cyc++;
        if (running) sample();
        in_valid = v; in_sob = s; in_eob = e; in_sync = sy; in_data = d;
        if (v) begin
            exp_t x;
            x.d = d; x.sob = s; x.sync = sy; x.t_drv = cyc; x.was_empty = (q.size() == 0);
            q.push_back(x);
        end
        prev_valid = v; prev_sob = s; prev_eob = e;
    endtask

    // burst table: sync, words, gap, burst flags
    typedef struct packed {
        logic [7:0] sync;
        logic [5:0] len;
        logic [5:0] gap;
        logic       burst;
    } row_t;

    localparam row_t ROWS [10] = '{
        '{8'h5A, 6'd1,  6'd6, 1'b1},
        '{8'h00, 6'd3,  6'd5, 1'b0},
        '{8'hC3, 6'd8,  6'd2, 1'b1},
        '{8'hFF, 6'd2,  6'd0, 1'b1},
        '{8'h11, 6'd2,  6'd4, 1'b1},
        '{8'h00, 6'd20, 6'd9, 1'b0},
        '{8'h7E, 6'd30, 6'd3, 1'b1},
        '{8'h42, 6'd1,  6'd0, 1'b1},
        '{8'h24, 6'd1,  6'd7, 1'b1},
        '{8'h99, 6'd40, 6'd12, 1'b1}
    };

    initial begin
        int k = 0;
        for (int l = 0; l < LANES; l++) crc[l] = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        chk(lane_hdr == {LANES{2'b10}}, "R10 idle during reset", lane_hdr, {LANES{2'b10}});
        chk(lane_word == {LANES{8'h1E, 56'h0}}, "R10 idle payload in reset", lane_word, {LANES{8'h1E, 56'h0}});
        chk(error == 3'b000, "R10 error clear in reset", error, 0);
        rst = 1'b0;
        running = 1;
        cur_l = clamp(meta_len);
        wcount = 0;
        // table walk
        for (int r = 0; r < 10; r++) begin
            for (int j = 0; j < ROWS[r].len; j++) begin
                step(1'b1, ROWS[r].burst && j == 0, ROWS[r].burst && j == ROWS[r].len - 1, ROWS[r].sync, mk(k));
                k++;
            end
            for (int j = 0; j < ROWS[r].gap; j++) step(0, 0, 0, 8'h0, '0);
        end
        // flood of single-word bursts forces buffer overflow (R8, R9)
        for (int j = 0; j < 40; j++) begin
            step(1'b1, 1'b1, j[0], 8'(j + 3), mk(k));
            k++;
        end
        for (int j = 0; j < 20; j++) step(0, 0, 0, 8'h0, '0);
        chk(n_drop > 0, "R8 overflow observed", n_drop, 1);
        chk(q.size() == 0, "R4 all accepted words delivered", q.size(), 0);
        // metaframe length changes (R5, R6)
        meta_len = 13'd300;
        for (int j = 0; j < 700; j++) step(0, 0, 0, 8'h0, '0);
        meta_len = 13'd50;
        for (int j = 0; j < 30; j++) begin
            step(1'b1, j == 0, j == 29, 8'hE7, mk(k));
            k++;
        end
        for (int j = 0; j < 600; j++) step(0, 0, 0, 8'h0, '0);
        chk(n_diag >= 5, "R5 diagnostic words seen", n_diag, 5);
        chk(q.size() == 0, "R4 final drain", q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule